// File: doc/BRIEF.md
# Receive Object Interrupt and Overrun Tracker

This block keeps the interrupt and overrun state for a bank of 64 hardware receive message objects in a CAN acceptance-filter store. A storage engine, outside this block, copies every accepted frame into an object's memory as a burst of several word writes. The block sees only two strobes from that burst: one for the first word and one for the last. Each strobe carries the index of the target object and an accept flag.

For each object the block holds a two-bit semaphore, an interrupt-pending flag and a message-lost flag. A frame becomes pending once its last word has been stored. The lost flag is decided again at the first word of every new frame. If the previous frame was still pending at that moment, it has been overwritten. Software acknowledges an object by clearing its semaphore, and that clear also drops the pending flag. A single interrupt line is high whenever some object is both pending and enabled.

Top module: `rxobj_irq_tracker`

## Requirements
- R1: The block handles 64 objects, numbered 0 to 63. A strobe aimed at one index changes only that object's semaphore, pending flag and lost flag.
- R2: A pending flag is set only when the last-word strobe has `wr_accept` high and the object's bit in `irq_en` is 1. A strobe with `wr_accept` low changes nothing for that object.
- R3: The pending flag rises on the clock edge that samples the last-word strobe, and not on the first-word strobe. It is visible on `pend` one cycle after the strobe.
- R4: A software clear of an object (`sw_clr` with `sw_idx`) sets that object's semaphore to 00 and its pending flag to 0.
- R5: An accepted first-word strobe to an object whose pending flag is 1 sets that object's lost flag.
- R6: An accepted first-word strobe to an object whose pending flag is 0 clears that object's lost flag. At no other time does the lost flag change.
- R7: An object's semaphore, at `sem[2*i+1:2*i]`, reads 01 after an accepted first-word strobe and 11 after an accepted last-word strobe.
- R8: `irq` is 1 exactly when at least one object has both its pending flag and its `irq_en` bit set.
- R9: When a software clear and an accepted last-word strobe hit the same object in the same cycle, the hardware wins. The semaphore becomes 11, and the pending flag becomes 1 if the object is enabled.
- R10: Clearing an `irq_en` bit leaves an already-set pending flag at 1. It only blocks new pending flags and masks `irq`.
- R11: While `rst_n` is low, every semaphore, pending flag and lost flag is cleared on each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_first | input | 1 | Strobe for the first word write of a frame |
| wr_last | input | 1 | Strobe for the last word write of a frame |
| wr_idx | input | 6 | Object index for the write strobes |
| wr_accept | input | 1 | The frame being written was accepted |
| sw_clr | input | 1 | Software semaphore-clear strobe |
| sw_idx | input | 6 | Object index for the software clear |
| irq_en | input | 64 | Per-object interrupt enable bits |
| pend | output | 64 | Per-object interrupt-pending flags |
| lost | output | 64 | Per-object message-lost flags |
| sem | output | 128 | Per-object 2-bit semaphores, object i at bits 2i+1:2i |
| irq | output | 1 | Aggregate interrupt |

## Verification
The bench drives a plain frame into an enabled object and checks that `pend` stays low after the first-word strobe and rises only after the last-word strobe. This separates "pending at the last word" from "pending at the first word". It then stores two frames back to back into one object, and after that stores a frame following a software clear. Together these show that the lost flag is taken from the pending state at the first word, in both directions.

Further frames go to a disabled object and with the accept flag low, to show that both conditions gate the pending flag. A software clear is placed in the same cycle as a last-word strobe to show that the hardware set wins. Finally, the enable bit is dropped while the object is pending, to show that the enable masks `irq` without erasing the flag.

// File: rtl/rxobj_pkg.sv
// Shared types for the receive-object interrupt tracker.
// Assumes: semaphore codes are read by software, so the values are fixed.
package rxobj_pkg;
    typedef enum logic [1:0] {
        SEM_IDLE = 2'b00,
        SEM_BUSY = 2'b01,
        SEM_DONE = 2'b11
    } sem_e;
endpackage

// File: rtl/rxobj_index_decode.sv
// Turns a strobe and an object index into a one-hot hit vector.
// Assumes: the index is always below N; an index at N or above hits nothing.
module rxobj_index_decode #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             strobe,
    input  logic [IDX_W-1:0] idx,
    output logic [N-1:0]     hit
);
    // One comparator per object.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = strobe && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/rxobj_flag_cell.sv
// Per-object state: semaphore, pending flag and lost flag.
// Assumes: the hit inputs come from registered or stable decode logic in
// the same clock domain. Hardware writes take priority over software clears.
module rxobj_flag_cell
    import rxobj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic first_hit,
    input  logic last_hit,
    input  logic clr_hit,
    input  logic en,
    output logic pend_q,
    output logic lost_q,
    output sem_e sem_q
);
    // Lost flag: set again from the pending state at each new frame's first word.
    always_ff @(posedge clk) begin
        if (!rst_n)         lost_q <= 1'b0;
        else if (first_hit) lost_q <= pend_q;
    end

    // Semaphore: the engine's writes win over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         sem_q <= SEM_IDLE;
        else if (last_hit)  sem_q <= SEM_DONE;
        else if (first_hit) sem_q <= SEM_BUSY;
        else if (clr_hit)   sem_q <= SEM_IDLE;
    end

    // Pending flag: set at the last word when enabled, dropped by a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)               pend_q <= 1'b0;
        else if (last_hit && en)  pend_q <= 1'b1;
        else if (clr_hit)         pend_q <= 1'b0;
    end

    assert_pend_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(last_hit && en));
    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !last_hit) |=> !pend_q);
    assert_lost_eval_R5: assert property (@(posedge clk) disable iff (!rst_n)
        first_hit |=> (lost_q == $past(pend_q)));
    assert_lost_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !first_hit |=> $stable(lost_q));
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_hit && en) |=> (pend_q && sem_q == SEM_DONE));
endmodule

// File: rtl/rxobj_irq_reduce.sv
// Combines the pending flags with the enables into one interrupt line.
// Assumes: the two vectors have the same width.
module rxobj_irq_reduce #(
    parameter int N = 64
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    output logic         irq
);
    // Any object that is both pending and enabled raises the line.
    always_comb irq = |(pend & en);
endmodule

// File: rtl/rxobj_irq_tracker.sv
// Tracks the interrupt-pending and message-lost flags of each receive
// object from the storage engine's first-word and last-word strobes.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module rxobj_irq_tracker
    import rxobj_pkg::*;
#(
    parameter int  NUM_OBJ = 64,
    localparam int IDX_W   = $clog2(NUM_OBJ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_first,
    input  logic                 wr_last,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_accept,
    input  logic                 sw_clr,
    input  logic [IDX_W-1:0]     sw_idx,
    input  logic [NUM_OBJ-1:0]   irq_en,
    output logic [NUM_OBJ-1:0]   pend,
    output logic [NUM_OBJ-1:0]   lost,
    output logic [2*NUM_OBJ-1:0] sem,
    output logic                 irq
);
    logic [NUM_OBJ-1:0] first_vec, last_vec, clr_vec;

    rxobj_index_decode #(.N(NUM_OBJ), .IDX_W(IDX_W)) u_dec_first (
        .strobe(wr_first && wr_accept), .idx(wr_idx), .hit(first_vec));
    rxobj_index_decode #(.N(NUM_OBJ), .IDX_W(IDX_W)) u_dec_last (
        .strobe(wr_last && wr_accept), .idx(wr_idx), .hit(last_vec));
    rxobj_index_decode #(.N(NUM_OBJ), .IDX_W(IDX_W)) u_dec_clr (
        .strobe(sw_clr), .idx(sw_idx), .hit(clr_vec));

    // One state cell per object.
    for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
        sem_e sem_i;
        rxobj_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .first_hit(first_vec[i]), .last_hit(last_vec[i]),
            .clr_hit(clr_vec[i]), .en(irq_en[i]),
            .pend_q(pend[i]), .lost_q(lost[i]), .sem_q(sem_i));
        assign sem[2*i +: 2] = sem_i;
    end

    rxobj_irq_reduce #(.N(NUM_OBJ)) u_irq (.pend(pend), .en(irq_en), .irq(irq));

    assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first_vec) && $onehot0(last_vec));
    assert_irq_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((pend & irq_en) != '0));
endmodule

// File: tb/rxobj_irq_tracker_test.sv
// Directed bench: one task per scenario, each checking its own results.
module rxobj_irq_tracker_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_first, wr_last, wr_accept, sw_clr;
    logic [5:0]   wr_idx, sw_idx;
    logic [63:0]  irq_en;
    logic [63:0]  pend, lost;
    logic [127:0] sem;
    logic         irq;
    int           errors = 0;
    int           checks = 0;

    always #4 clk = ~clk;

    rxobj_irq_tracker uut (
        .clk(clk), .rst_n(rst_n), .wr_first(wr_first), .wr_last(wr_last),
        .wr_idx(wr_idx), .wr_accept(wr_accept), .sw_clr(sw_clr), .sw_idx(sw_idx),
        .irq_en(irq_en), .pend(pend), .lost(lost), .sem(sem), .irq(irq));

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives one cycle of strobes at a falling edge; results are visible at the next falling edge.
    task automatic step(input logic f, input logic l, input logic [5:0] i,
                        input logic a, input logic c, input logic [5:0] ci);
        wr_first = f; wr_last = l; wr_idx = i; wr_accept = a; sw_clr = c; sw_idx = ci;
        @(negedge clk);
        wr_first = 0; wr_last = 0; wr_accept = 0; sw_clr = 0;
    endtask

    function automatic logic [1:0] sem_of(input int i);
        return sem[2*i +: 2];
    endfunction

    task automatic t_reset;
        check("R11 pend after reset", pend, 0);
        check("R11 lost after reset", lost, 0);
        check("R11 sem after reset", sem, 0);
        check("R8 irq after reset", irq, 0);
    endtask

    task automatic t_normal;
        step(1, 0, 6'd5, 1, 0, 0);
        check("R3 no pend after first word", pend, 0);
        check("R7 sem busy", sem_of(5), 2'b01);
        step(0, 1, 6'd5, 1, 0, 0);
        check("R3 pend after last word", pend, 64'd1 << 5);
        check("R7 sem done", sem_of(5), 2'b11);
        check("R1 other semaphores idle", sem & ~(128'h3 << 10), 0);
        check("R8 irq high", irq, 1);
        step(0, 0, 0, 0, 1, 6'd5);
        check("R4 pend cleared", pend, 0);
        check("R4 sem idle", sem_of(5), 2'b00);
        check("R8 irq low", irq, 0);
    endtask

    task automatic t_overrun;
        step(1, 0, 6'd63, 1, 0, 0);
        step(0, 1, 6'd63, 1, 0, 0);
        check("R6 no lost on first frame", lost, 0);
        step(1, 0, 6'd63, 1, 0, 0);
        check("R5 lost set on overrun", lost, 64'd1 << 63);
        step(0, 1, 6'd63, 1, 0, 0);
        check("R6 lost holds at last word", lost, 64'd1 << 63);
        step(0, 0, 0, 0, 1, 6'd63);
        step(1, 0, 6'd63, 1, 0, 0);
        check("R6 lost cleared on fresh frame", lost, 0);
        step(0, 1, 6'd63, 1, 0, 0);
        step(0, 0, 0, 0, 1, 6'd63);
    endtask

    task automatic t_gating;
        irq_en[10] = 1'b0;
        step(1, 0, 6'd10, 1, 0, 0);
        step(0, 1, 6'd10, 1, 0, 0);
        check("R2 disabled object not pending", pend, 0);
        check("R7 disabled object sem done", sem_of(10), 2'b11);
        step(0, 0, 0, 0, 1, 6'd10);
        irq_en[10] = 1'b1;
        step(1, 0, 6'd11, 0, 0, 0);
        step(0, 1, 6'd11, 0, 0, 0);
        check("R2 unaccepted frame ignored pend", pend, 0);
        check("R2 unaccepted frame ignored sem", sem, 0);
    endtask

    task automatic t_collision;
        step(1, 0, 6'd0, 1, 0, 0);
        step(0, 1, 6'd0, 1, 1, 6'd0);
        check("R9 set wins pend", pend, 64'd1);
        check("R9 set wins sem", sem_of(0), 2'b11);
    endtask

    task automatic t_enable_drop;
        irq_en[0] = 1'b0;
        @(negedge clk);
        check("R10 pend kept after enable drop", pend, 64'd1);
        check("R8 irq masked", irq, 0);
        irq_en[0] = 1'b1;
        @(negedge clk);
        check("R8 irq back", irq, 1);
        step(0, 0, 0, 0, 1, 6'd0);
        check("R4 final clear", pend, 0);
    endtask

    initial begin
        rst_n = 0; wr_first = 0; wr_last = 0; wr_accept = 0; sw_clr = 0;
        wr_idx = 0; sw_idx = 0; irq_en = '1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_normal();
        t_overrun();
        t_gating();
        t_collision();
        t_enable_drop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule